// File: doc/BRIEF.md
# Device MMU control and fault register block

This block is the software-visible register set of a device-side address translation unit. A 32-bit register port with byte offsets gives access to a control register that turns translation on, turns it off or asks for it to be stalled, and to a status bit that confirms the stall has taken hold. The block also holds the translation table base, a set of fault status bits with write-one-to-clear, the last faulting address for each class of fault, a read-only version word and two inclusive address windows used for prefetch.

The translation path sits outside. It reports faults to this block as a type and an address, and it reports when it has no transfer in flight. The block tells the path whether translation is on and whether it must stall. Any accepted fault stalls the path at once and raises the interrupt line. The stall holds until software writes the enable code again, and software clearing the fault bit does not release it. For each window the block also flags whether a given translation address falls inside it.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset the control register (offset 0x000) reads 0, the blocked status (0x008) and the fault status (0x018) read 0, and `mmu_on`, `xlat_stall` and `irq` are low.
- R2: Writing 0x5 to offset 0x000 turns translation on (`mmu_on` high, control reads 0x5) and writing 0x0 turns it off (control reads 0x0). A write of any other value is ignored, and so is 0x7 while translation is off.
- R3: Writing 0x7 while translation is on raises `xlat_stall` in the next cycle and the control register reads 0x7. Bit 0 of 0x008 stays 0 while `xlat_idle` is low and reads 1 from the cycle after `xlat_idle` is seen high.
- R4: An accepted fault sets bit `flt_type` of 0x018 in the next cycle and `irq` is the OR of all bits of 0x018. The bit positions are: page fault 0, read multi-hit 1, write multi-hit 2, bus error 3, read security 4, read access 5, write security 6, write access 7.
- R5: An accepted fault forces the blocked state (bit 0 of 0x008 is 1, `xlat_stall` high) whatever `xlat_idle` is. The state holds through writes of 0x7 and through clearing the fault bits, and only a write of 0x5 (or 0x0) to control leaves it.
- R6: On an accepted fault its address is stored by class: page fault at 0x024, write faults (types 2, 6, 7) at 0x028, read faults (types 1, 4, 5) at 0x02C, bus error at 0x030. The other address registers keep their value.
- R7: Writing a mask to 0x01C clears the fault status bits where the mask is 1 and keeps the others. When a fault of a bit arrives in the same cycle as its clear, the bit stays set.
- R8: A fault reported while translation is off is ignored: fault status, addresses and `irq` do not change.
- R9: Offset 0x014 holds the table base with bits [13:0] forced to 0 on write. The stored value reads back and drives `tbl_base`.
- R10: Offset 0x034 reads the major version in bits [31:28] (default 3) and the minor version in bits [27:0] (default 0x10), giving 0x30000010. Writes to it are ignored.
- R11: Window 0 start and end sit at 0x04C and 0x050, window 1 at 0x054 and 0x058. They read back as written and `pf_hit[i]` is high when start_i <= `xlat_addr` <= end_i, both ends inclusive.
- R12: Reads of unmapped offsets and of the clear register 0x01C return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| xlat_idle | input | 1 | Translation path has no transfer in flight |
| flt_valid | input | 1 | Fault report strobe from the translation path |
| flt_type | input | 3 | Fault type, equals its status bit position |
| flt_addr | input | 32 | Address that faulted |
| xlat_addr | input | 32 | Translation address compared against the windows |
| mmu_on | output | 1 | Translation is on |
| xlat_stall | output | 1 | Translation path must stall |
| irq | output | 1 | Fault interrupt, OR of the fault status bits |
| tbl_base | output | 32 | Table base for the translation path |
| pf_hit | output | 2 | Per window: `xlat_addr` lies inside it |

## Verification
The bench goes after the stall handshake: a design that set the blocked bit at the block request instead of after `xlat_idle` would report a stall before the path has drained. It clears fault bits while the unit is held by a fault, which catches a design that lets the interrupt clear release the stall, and it raises a fault in the very cycle its bit is cleared, which a design with clear over set would lose. It also checks that each fault class lands only in its own address register, that window comparisons hold at both end addresses and one past them, and that faults while off leave no trace.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

  localparam int REG_W = 32;

  // register byte offsets
  localparam int OFF_CTRL    = 'h000;
  localparam int OFF_STATUS  = 'h008;
  localparam int OFF_TBASE   = 'h014;
  localparam int OFF_FSTS    = 'h018;
  localparam int OFF_FCLR    = 'h01C;
  localparam int OFF_A_PAGE  = 'h024;
  localparam int OFF_A_WRITE = 'h028;
  localparam int OFF_A_READ  = 'h02C;
  localparam int OFF_A_BUS   = 'h030;
  localparam int OFF_VER     = 'h034;
  localparam int OFF_WIN0    = 'h04C;
  localparam int WIN_STRIDE  = 8;

  // control codes
  localparam logic [REG_W-1:0] CODE_OFF = 32'h0;
  localparam logic [REG_W-1:0] CODE_ON  = 32'h5;
  localparam logic [REG_W-1:0] CODE_BLK = 32'h7;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_REQ  = 2'd2,
    ST_HELD = 2'd3
  } mmu_state_e;

  // address classes for fault capture
  localparam int CLS_PAGE  = 0;
  localparam int CLS_WRITE = 1;
  localparam int CLS_READ  = 2;
  localparam int CLS_BUS   = 3;
  localparam int NUM_CLS   = 4;

  function automatic logic [1:0] cls_of(input int ftype);
    logic [1:0] c;
    case (ftype)
      0:       c = 2'(CLS_PAGE);
      1, 4, 5: c = 2'(CLS_READ);
      2, 6, 7: c = 2'(CLS_WRITE);
      default: c = 2'(CLS_BUS);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mmu_ctl_fsm.sv
module mmu_ctl_fsm
  import mmu_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_code,
  input  logic             xlat_idle,
  input  logic             flt_take,
  output mmu_state_e       state
);

  mmu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (flt_take) begin
      state_d = ST_HELD;
    end else if (ctl_wr) begin
      if (ctl_code == CODE_ON) begin
        state_d = ST_RUN;
      end else if (ctl_code == CODE_OFF) begin
        state_d = ST_OFF;
      end else if (ctl_code == CODE_BLK) begin
        if (state_q == ST_RUN) state_d = ST_REQ;
      end
    end else if (state_q == ST_REQ && xlat_idle) begin
      state_d = ST_HELD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/mmu_flt_log.sv
module mmu_flt_log
  import mmu_regs_pkg::*;
#(
  parameter int NUM_FLT = 8,
  localparam int TYPE_W = $clog2(NUM_FLT)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_take,
  input  logic [TYPE_W-1:0]  flt_type,
  input  logic [REG_W-1:0]   flt_addr,
  input  logic               clr_wr,
  input  logic [NUM_FLT-1:0] clr_mask,
  output logic [NUM_FLT-1:0] sts,
  output logic [REG_W-1:0]   cls_addr [NUM_CLS]
);

  logic [1:0] flt_cls;
  assign flt_cls = cls_of(int'(flt_type));

  // one status bit per fault type, set wins over clear
  for (genvar b = 0; b < NUM_FLT; b++) begin : g_sts
    logic set_b, clr_b, q, d;
    assign set_b = flt_take && (int'(flt_type) == b);
    assign clr_b = clr_wr && clr_mask[b];
    always_comb begin
      d = q;
      if (clr_b) d = 1'b0;
      if (set_b) d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign sts[b] = q;
  end

  // one address register per class
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_addr
    logic             cap;
    logic [REG_W-1:0] q, d;
    assign cap = flt_take && (int'(flt_cls) == c);
    always_comb d = cap ? flt_addr : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign cls_addr[c] = q;
  end

endmodule

// File: rtl/mmu_pf_win.sv
module mmu_pf_win
  import mmu_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_wr,
  input  logic             hi_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] probe,
  output logic [REG_W-1:0] lo,
  output logic [REG_W-1:0] hi,
  output logic             hit
);

  logic [REG_W-1:0] lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    lo_d = lo_wr ? wdata : lo_q;
    hi_d = hi_wr ? wdata : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo  = lo_q;
  assign hi  = hi_q;
  assign hit = (probe >= lo_q) && (probe <= hi_q);

endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_FLT   = 8,
  parameter int NUM_WIN   = 2,
  parameter int TB_ALIGN  = 14,
  parameter int VER_MAJOR = 3,
  parameter int VER_MINOR = 'h10,
  localparam int TYPE_W   = $clog2(NUM_FLT)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               xlat_idle,
  input  logic               flt_valid,
  input  logic [TYPE_W-1:0]  flt_type,
  input  logic [REG_W-1:0]   flt_addr,
  input  logic [REG_W-1:0]   xlat_addr,
  output logic               mmu_on,
  output logic               xlat_stall,
  output logic               irq,
  output logic [REG_W-1:0]   tbl_base,
  output logic [NUM_WIN-1:0] pf_hit
);

  localparam logic [REG_W-1:0] VER_WORD =
    {4'(VER_MAJOR), 28'(VER_MINOR)};
  localparam logic [REG_W-1:0] TB_MASK = ~((REG_W'(1) << TB_ALIGN) - 1);

  function automatic logic at(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  // control state
  mmu_state_e       state;
  logic             flt_take;
  logic             ctl_wr;

  assign ctl_wr   = reg_wr && at(reg_addr, OFF_CTRL);
  assign mmu_on   = (state != ST_OFF);
  assign flt_take = flt_valid && mmu_on;

  mmu_ctl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_code  (reg_wdata),
    .xlat_idle (xlat_idle),
    .flt_take  (flt_take),
    .state     (state)
  );

  assign xlat_stall = (state == ST_REQ) || (state == ST_HELD);

  // fault status and addresses
  logic [NUM_FLT-1:0] fsts;
  logic [REG_W-1:0]   faddr [NUM_CLS];
  logic               clr_wr;

  assign clr_wr = reg_wr && at(reg_addr, OFF_FCLR);

  mmu_flt_log #(.NUM_FLT(NUM_FLT)) u_flt (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt_take (flt_take),
    .flt_type (flt_type),
    .flt_addr (flt_addr),
    .clr_wr   (clr_wr),
    .clr_mask (reg_wdata[NUM_FLT-1:0]),
    .sts      (fsts),
    .cls_addr (faddr)
  );

  assign irq = |fsts;

  // table base
  logic [REG_W-1:0] tb_q, tb_d;
  logic             tb_wr;

  assign tb_wr = reg_wr && at(reg_addr, OFF_TBASE);

  always_comb tb_d = tb_wr ? (reg_wdata & TB_MASK) : tb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_d;
  end

  assign tbl_base = tb_q;

  // prefetch windows
  logic [REG_W-1:0] win_lo [NUM_WIN];
  logic [REG_W-1:0] win_hi [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int LO_OFF = OFF_WIN0 + w * WIN_STRIDE;
    localparam int HI_OFF = LO_OFF + 4;
    mmu_pf_win u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .lo_wr (reg_wr && at(reg_addr, LO_OFF)),
      .hi_wr (reg_wr && at(reg_addr, HI_OFF)),
      .wdata (reg_wdata),
      .probe (xlat_addr),
      .lo    (win_lo[w]),
      .hi    (win_hi[w]),
      .hit   (pf_hit[w])
    );
  end

  // read mux
  logic [REG_W-1:0] ctl_rd;

  always_comb begin
    case (state)
      ST_OFF:  ctl_rd = CODE_OFF;
      ST_RUN:  ctl_rd = CODE_ON;
      default: ctl_rd = CODE_BLK;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    if (at(reg_addr, OFF_CTRL))    reg_rdata = ctl_rd;
    if (at(reg_addr, OFF_STATUS))  reg_rdata = {{(REG_W-1){1'b0}}, state == ST_HELD};
    if (at(reg_addr, OFF_TBASE))   reg_rdata = tb_q;
    if (at(reg_addr, OFF_FSTS))    reg_rdata = REG_W'(fsts);
    if (at(reg_addr, OFF_A_PAGE))  reg_rdata = faddr[CLS_PAGE];
    if (at(reg_addr, OFF_A_WRITE)) reg_rdata = faddr[CLS_WRITE];
    if (at(reg_addr, OFF_A_READ))  reg_rdata = faddr[CLS_READ];
    if (at(reg_addr, OFF_A_BUS))   reg_rdata = faddr[CLS_BUS];
    if (at(reg_addr, OFF_VER))     reg_rdata = VER_WORD;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (at(reg_addr, OFF_WIN0 + w * WIN_STRIDE))     reg_rdata = win_lo[w];
      if (at(reg_addr, OFF_WIN0 + w * WIN_STRIDE + 4)) reg_rdata = win_hi[w];
    end
  end

endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk #(
  parameter int ADDR_W = 12
)(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              flt_valid,
  input logic              mmu_on,
  input logic              xlat_stall,
  input logic              irq
);

  logic ctl_wr, ctl_release, clr_all;
  assign ctl_wr      = reg_wr && (reg_addr == ADDR_W'('h000));
  assign ctl_release = ctl_wr && (reg_wdata == 32'h5 || reg_wdata == 32'h0);
  assign clr_all     = reg_wr && (reg_addr == ADDR_W'('h01C)) && (reg_wdata[7:0] == 8'hFF);

  // R4
  fault_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && mmu_on |=> irq);

  // R5
  fault_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && mmu_on |=> xlat_stall);

  // R5
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_stall && !ctl_release |=> xlat_stall);

  // R7
  clear_all_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all && !flt_valid |=> !irq);

  // R8
  off_fault_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mmu_on && flt_valid && !reg_wr |=> $stable(irq));

  // R2
  off_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mmu_on |-> !xlat_stall);

endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .flt_valid  (flt_valid),
  .mmu_on     (mmu_on),
  .xlat_stall (xlat_stall),
  .irq        (irq)
);

// File: tb/mmu_ctl_regs_tb_top.sv
module mmu_ctl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xlat_idle = 1'b0;
  logic        flt_valid = 1'b0;
  logic [2:0]  flt_type = '0;
  logic [31:0] flt_addr = '0;
  logic [31:0] xlat_addr = '0;
  logic        mmu_on, xlat_stall, irq;
  logic [31:0] tbl_base;
  logic [1:0]  pf_hit;

  always #2 clk = ~clk;

  mmu_ctl_regs dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .xlat_idle  (xlat_idle),
    .flt_valid  (flt_valid),
    .flt_type   (flt_type),
    .flt_addr   (flt_addr),
    .xlat_addr  (xlat_addr),
    .mmu_on     (mmu_on),
    .xlat_stall (xlat_stall),
    .irq        (irq),
    .tbl_base   (tbl_base),
    .pf_hit     (pf_hit)
  );

  typedef enum int {K_RD, K_IRQ, K_STALL, K_ON, K_HIT, K_TB} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // monitor: compares every queued expectation away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = reg_rdata;
        K_IRQ:   act = 32'(irq);
        K_STALL: act = 32'(xlat_stall);
        K_ON:    act = 32'(mmu_on);
        K_HIT:   act = 32'(pf_hit);
        default: act = tbl_base;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(kind_e k, logic [11:0] a, logic [31:0] e, string tag);
    tick();
    if (k == K_RD) reg_addr = a;
    q.push_back('{k, e, tag});
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    tick();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic fault(logic [2:0] t, logic [31:0] a);
    tick();
    flt_valid = 1'b1; flt_type = t; flt_addr = a;
    tick();
    flt_valid = 1'b0;
  endtask

  task automatic fault_and_clear(logic [2:0] t, logic [31:0] a, logic [31:0] m);
    tick();
    flt_valid = 1'b1; flt_type = t; flt_addr = a;
    reg_wr = 1'b1; reg_addr = 12'h01C; reg_wdata = m;
    tick();
    flt_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(K_RD, 12'h000, 32'h0, "R1 ctrl");
    chk(K_RD, 12'h008, 32'h0, "R1 status");
    chk(K_RD, 12'h018, 32'h0, "R1 fault status");
    chk(K_IRQ, 0, 0, "R1 irq");
    chk(K_STALL, 0, 0, "R1 stall");
    chk(K_ON, 0, 0, "R1 mmu_on");

    // R8 fault while off
    fault(3'd0, 32'h1234_0000);
    chk(K_RD, 12'h018, 32'h0, "R8 status after off fault");
    chk(K_RD, 12'h024, 32'h0, "R8 page addr after off fault");
    chk(K_IRQ, 0, 0, "R8 irq");

    // R2 control codes
    wr(12'h000, 32'h7);
    chk(K_ON, 0, 0, "R2 block ignored while off");
    wr(12'h000, 32'h5);
    chk(K_ON, 0, 1, "R2 enable");
    chk(K_RD, 12'h000, 32'h5, "R2 ctrl enabled");
    wr(12'h000, 32'h3);
    chk(K_RD, 12'h000, 32'h5, "R2 bad code ignored");
    wr(12'h000, 32'h0);
    chk(K_ON, 0, 0, "R2 disable");
    chk(K_RD, 12'h000, 32'h0, "R2 ctrl disabled");
    wr(12'h000, 32'h5);

    // R3 block handshake
    xlat_idle = 1'b0;
    wr(12'h000, 32'h7);
    chk(K_STALL, 0, 1, "R3 stall after block");
    chk(K_RD, 12'h000, 32'h7, "R3 ctrl reads block");
    chk(K_RD, 12'h008, 32'h0, "R3 not blocked while busy");
    tick(); xlat_idle = 1'b1;
    tick(); xlat_idle = 1'b0;
    chk(K_RD, 12'h008, 32'h1, "R3 blocked after idle");
    wr(12'h000, 32'h5);
    chk(K_STALL, 0, 0, "R3 stall released");
    chk(K_RD, 12'h008, 32'h0, "R3 status released");

    // R4 R5 R6 fault capture and hold
    fault(3'd5, 32'hA000_1234);
    chk(K_RD, 12'h018, 32'h20, "R4 read access bit 5");
    chk(K_IRQ, 0, 1, "R4 irq");
    chk(K_RD, 12'h008, 32'h1, "R5 fault blocks");
    chk(K_STALL, 0, 1, "R5 fault stalls");
    chk(K_RD, 12'h02C, 32'hA000_1234, "R6 read fault addr");
    wr(12'h000, 32'h7);
    chk(K_RD, 12'h008, 32'h1, "R5 held through block write");
    wr(12'h01C, 32'h20);
    chk(K_IRQ, 0, 0, "R7 irq after clear");
    chk(K_RD, 12'h008, 32'h1, "R5 held after clear");
    wr(12'h000, 32'h5);
    chk(K_RD, 12'h008, 32'h0, "R5 released by enable");

    fault(3'd3, 32'h0BAD_0000);
    fault(3'd6, 32'h6666_0000);
    fault(3'd0, 32'h1111_0000);
    chk(K_RD, 12'h030, 32'h0BAD_0000, "R6 bus error addr");
    chk(K_RD, 12'h028, 32'h6666_0000, "R6 write fault addr");
    chk(K_RD, 12'h024, 32'h1111_0000, "R6 page fault addr");
    chk(K_RD, 12'h02C, 32'hA000_1234, "R6 read addr kept");
    chk(K_RD, 12'h018, 32'h49, "R4 bits 0 3 6");

    // R7 write one to clear
    wr(12'h01C, 32'h08);
    chk(K_RD, 12'h018, 32'h41, "R7 partial clear");
    fault_and_clear(3'd0, 32'h2222_0000, 32'h41);
    chk(K_RD, 12'h018, 32'h01, "R7 set wins over clear");
    wr(12'h01C, 32'h01);
    chk(K_RD, 12'h018, 32'h0, "R7 all clear");
    chk(K_IRQ, 0, 0, "R7 irq low");
    wr(12'h000, 32'h5);

    // R9 table base
    wr(12'h014, 32'h1234_5FFF);
    chk(K_RD, 12'h014, 32'h1234_4000, "R9 table base read");
    chk(K_TB, 0, 32'h1234_4000, "R9 table base port");

    // R10 version
    chk(K_RD, 12'h034, 32'h3000_0010, "R10 version");
    wr(12'h034, 32'hFFFF_FFFF);
    chk(K_RD, 12'h034, 32'h3000_0010, "R10 version read only");

    // R11 windows
    wr(12'h04C, 32'h0000_1000);
    wr(12'h050, 32'h0000_1FFF);
    wr(12'h054, 32'h0000_8000);
    wr(12'h058, 32'h0000_8000);
    chk(K_RD, 12'h050, 32'h0000_1FFF, "R11 window 0 end read");
    chk(K_RD, 12'h054, 32'h0000_8000, "R11 window 1 start read");
    xlat_addr = 32'h0000_1000;
    chk(K_HIT, 0, 32'h1, "R11 window 0 start inclusive");
    xlat_addr = 32'h0000_1FFF;
    chk(K_HIT, 0, 32'h1, "R11 window 0 end inclusive");
    xlat_addr = 32'h0000_2000;
    chk(K_HIT, 0, 32'h0, "R11 past window 0");
    xlat_addr = 32'h0000_0FFF;
    chk(K_HIT, 0, 32'h0, "R11 before window 0");
    xlat_addr = 32'h0000_8000;
    chk(K_HIT, 0, 32'h2, "R11 window 1 single address");

    // R12 unmapped
    wr(12'h004, 32'hFFFF_FFFF);
    chk(K_RD, 12'h004, 32'h0, "R12 unmapped read");
    chk(K_RD, 12'h0FC, 32'h0, "R12 far unmapped read");
    chk(K_RD, 12'h01C, 32'h0, "R12 clear reg reads zero");
    chk(K_RD, 12'h000, 32'h5, "R12 ctrl untouched");
    chk(K_RD, 12'h014, 32'h1234_4000, "R12 table base untouched");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule